// File: doc/BRIEF.md
# Posted-Write Bridge into a Slow Always-On Domain

This block lets a fast bus master write into registers that live in a slow, always-on clock domain without waiting for that domain. Each write to a target register is accepted in a single fast cycle and placed in a small in-order queue. The bridge then sends the writes across the clock boundary one at a time. Each transfer uses a toggle request and a toggle acknowledge, and both toggles pass through synchronising flops. On the slow side every delivered write shows up as a one-cycle strobe carrying a register index and a data word.

The bridge keeps one pending bit per target register. A pending bit is set when a write is accepted and cleared only when the slow side acknowledges that the write was applied. A second write to a register that still has a pending write is refused. A write that finds the queue full is refused too. Any refusal sets a sticky, write-1-to-clear status flag, which also drives the interrupt output. A status word shows whether any write is still outstanding. Writing a cancellation key to the gateway address empties the queue and voids the transfer in flight in the same cycle.

The bus address space has three regions. Addresses 0 to 15 are the target registers. Address 16 is the gateway. Address 17 is the status-clear location. Any other address is ignored.

Top module: `pwb_bridge`

## Requirements
- R1: Accepted writes are delivered on the slow side as one-cycle strobes (`s_wr_valid` never high two slow cycles running). They arrive in acceptance order, with index and data unchanged.
- R2: A write to a target address (0..15) that is accepted sets `pend_mask[index]` at the next fast edge.
- R3: A write to an index whose pending bit is set is dropped and never delivered. The earlier write to that index is still delivered.
- R4: The queue holds 4 waiting entries besides the transfer in flight. A target write arriving while `sts0[2]` (queue full) is set is dropped.
- R5: A pending bit clears only after the slow side has strobed that write out.
- R6: Every dropped write sets `sts0[4]` at the next fast edge. The bit stays set until cleared, and `irq` follows it.
- R7: A write to address 17 with data bit 4 set clears `sts0[4]`. The same write with data bit 4 clear leaves it unchanged.
- R8: `sts0[0]` is set while any pending bit is set. `sts0[1]` is set from the launch of a transfer until its acknowledge returns. All other `sts0` bits read 0.
- R9: Writing 0xA2C5 to address 16 clears every pending bit and empties the queue at the next fast edge. None of the cancelled writes, queued or in flight, is delivered.
- R10: Writing any value other than 0xA2C5 to address 16 has no effect on pending writes, and those writes are still delivered.
- R11: After a cancel, new writes are accepted at once (including to an index that was just cancelled) and are delivered once the voided transfer has finished its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_clk | input | 1 | Fast bus clock |
| f_rst_n | input | 1 | Fast-domain synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | 5 | Write address: 0..15 targets, 16 gateway, 17 status clear |
| bus_wdata | input | 16 | Write data |
| pend_mask | output | 16 | Per-register pending bits |
| sts0 | output | 8 | Status: [0] any pending, [1] transfer open, [2] queue full, [4] reject flag |
| irq | output | 1 | Reject interrupt, follows sts0[4] |
| s_clk | input | 1 | Slow always-on clock |
| s_rst_n | input | 1 | Slow-domain synchronous active-low reset |
| s_wr_valid | output | 1 | One-cycle strobe of a delivered write |
| s_wr_idx | output | 4 | Register index of the delivered write |
| s_wr_data | output | 16 | Data of the delivered write |

## Verification
The pending mask, reject flag, queue-full bit and cancel results all update one fast edge after the write cycle, so the bench checks them at the falling edge right after each write. The transfer-open bit needs one more edge, because a queued write launches only after it has been registered, and the bench samples it one cycle later. Slow-side delivery depends on how the two clocks line up. For that reason the bench polls the status word until it goes idle, within a bounded number of cycles, and then compares the full log of strobed writes against the expected order. Early clearing of a pending bit is caught by comparing each fast-cycle sample of the mask against a count of slow-side strobes taken on their rising edge.

// File: rtl/pwb_pkg.sv
// Package: shared widths, status bit positions and the queue entry type
// for the posted-write bridge. Assumes 16 target registers.
package pwb_pkg;
    localparam int IDX_W    = 4;
    localparam int DATA_W   = 16;
    localparam int STS_W    = 8;
    localparam int STS_ANY  = 0;
    localparam int STS_BUSY = 1;
    localparam int STS_FULL = 2;
    localparam int STS_REJ  = 4;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } pwb_entry_t;
endpackage

// File: rtl/pwb_sync.sv
// Module: pwb_sync
// Carries a single level bit into the clk domain through STAGES flops.
// Assumes the input changes no faster than the destination can sample.
module pwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwb_fifo.sv
// Module: pwb_fifo
// In-order queue of write entries with a one-cycle flush. The caller must
// push only when not full and pop only when not empty.
module pwb_fifo
    import pwb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  pwb_entry_t push_ent,
    input  logic       pop,
    input  logic       flush,
    output pwb_entry_t head,
    output logic       full,
    output logic       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    pwb_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed entry at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !flush) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    // Advance pointers and occupancy; flush empties the queue at once.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
endmodule

// File: rtl/pwb_rx.sv
// Module: pwb_rx
// Slow-domain receiver. Detects a toggle on the synchronised request,
// samples the held index/data/keep word (stable by then), strobes the
// write out if it was not voided, and returns the toggle as acknowledge.
module pwb_rx
    import pwb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic              req_tgl,
    input  pwb_entry_t        held,
    input  logic              held_keep,
    output logic              ack_tgl,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    logic req_s;
    logic req_seen;
    logic new_req;

    pwb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (s_clk),
        .rst_n (s_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    assign new_req = (req_s != req_seen);

    // Apply a new request once and echo it back as the acknowledge toggle.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
            wr_valid <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= new_req && held_keep;
            if (new_req) begin
                req_seen <= req_s;
                ack_tgl  <= req_s;
                wr_idx   <= held.idx;
                wr_data  <= held.data;
            end
        end
    end
endmodule

// File: rtl/pwb_bridge.sv
// Module: pwb_bridge (top)
// Posts fast-bus register writes into a queue and sends them one at a
// time into the slow domain. Keeps per-register pending bits, refuses
// duplicates and overflow, and flushes everything on a keyed cancel.
// Assumes at most one bus write per fast cycle.
module pwb_bridge
    import pwb_pkg::*;
#(
    parameter int              DEPTH       = 4,
    parameter int              ADDR_W      = 5,
    parameter int              SYNC_STAGES = 2,
    parameter logic [4:0]      GW_ADDR     = 5'h10,
    parameter logic [4:0]      STS_ADDR    = 5'h11,
    parameter logic [15:0]     CANCEL_KEY  = 16'hA2C5
) (
    input  logic              f_clk,
    input  logic              f_rst_n,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       pend_mask,
    output logic [7:0]        sts0,
    output logic              irq,
    input  logic              s_clk,
    input  logic              s_rst_n,
    output logic              s_wr_valid,
    output logic [3:0]        s_wr_idx,
    output logic [15:0]       s_wr_data
);
    localparam int NREG = 1 << IDX_W;

    logic [IDX_W-1:0]  wr_idx;
    logic              is_tgt, is_cancel, is_clr;
    logic              reject, accept, launch, ack_evt;
    logic [NREG-1:0]   pend_q, pend_d;
    logic              rej_q;
    logic              q_full, q_empty;
    pwb_entry_t        q_head, push_ent, tx_ent;
    logic              tx_busy, tx_keep, req_tgl;
    logic              ack_tgl, ack_s, ack_seen;

    // Decode the bus write into its target, gateway and status roles.
    always_comb begin
        wr_idx    = bus_addr[IDX_W-1:0];
        is_tgt    = bus_wr && (bus_addr[ADDR_W-1:IDX_W] == '0);
        is_cancel = bus_wr && (bus_addr == GW_ADDR) && (bus_wdata == CANCEL_KEY);
        is_clr    = bus_wr && (bus_addr == STS_ADDR) && bus_wdata[STS_REJ];
        reject    = is_tgt && (pend_q[wr_idx] || q_full);
        accept    = is_tgt && !reject;
        launch    = !tx_busy && !q_empty && !is_cancel;
        ack_evt   = (ack_s != ack_seen);
        push_ent  = '{idx: wr_idx, data: bus_wdata};
    end

    pwb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (f_clk),
        .rst_n    (f_rst_n),
        .push     (accept),
        .push_ent (push_ent),
        .pop      (launch),
        .flush    (is_cancel),
        .head     (q_head),
        .full     (q_full),
        .empty    (q_empty)
    );

    // Next pending mask: acknowledged write clears, accepted write sets.
    always_comb begin
        pend_d = pend_q;
        if (ack_evt && tx_keep) pend_d[tx_ent.idx] = 1'b0;
        if (accept)             pend_d[wr_idx]     = 1'b1;
        if (is_cancel)          pend_d             = '0;
    end

    // Register the pending mask.
    always_ff @(posedge f_clk) begin
        if (!f_rst_n) pend_q <= '0;
        else          pend_q <= pend_d;
    end

    // Sticky reject flag: set on any refusal, write-1-to-clear.
    always_ff @(posedge f_clk) begin
        if (!f_rst_n)    rej_q <= 1'b0;
        else if (reject) rej_q <= 1'b1;
        else if (is_clr) rej_q <= 1'b0;
    end

    // Launch the queue head across the boundary and wait for its acknowledge.
    always_ff @(posedge f_clk) begin
        if (!f_rst_n) begin
            tx_busy  <= 1'b0;
            tx_keep  <= 1'b0;
            req_tgl  <= 1'b0;
            tx_ent   <= '0;
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ack_s;
            if (ack_evt) tx_busy <= 1'b0;
            if (launch) begin
                tx_busy <= 1'b1;
                tx_keep <= 1'b1;
                req_tgl <= ~req_tgl;
                tx_ent  <= q_head;
            end
            if (is_cancel) tx_keep <= 1'b0;
        end
    end

    pwb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (f_clk),
        .rst_n (f_rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    pwb_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .s_clk     (s_clk),
        .s_rst_n   (s_rst_n),
        .req_tgl   (req_tgl),
        .held      (tx_ent),
        .held_keep (tx_keep),
        .ack_tgl   (ack_tgl),
        .wr_valid  (s_wr_valid),
        .wr_idx    (s_wr_idx),
        .wr_data   (s_wr_data)
    );

    // Assemble the status word and interrupt.
    always_comb begin
        sts0           = '0;
        sts0[STS_ANY]  = |pend_q;
        sts0[STS_BUSY] = tx_busy;
        sts0[STS_FULL] = q_full;
        sts0[STS_REJ]  = rej_q;
        irq            = rej_q;
        pend_mask      = pend_q;
    end
endmodule

// File: rtl/pwb_bridge_chk.sv
// Module: pwb_bridge_chk
// Port-level temporal checks for pwb_bridge, attached with bind.
module pwb_bridge_chk
    import pwb_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter logic [4:0]  GW_ADDR    = 5'h10,
    parameter logic [15:0] CANCEL_KEY = 16'hA2C5,
    parameter logic [4:0]  STS_ADDR   = 5'h11
) (
    input logic        f_clk,
    input logic        f_rst_n,
    input logic        s_clk,
    input logic        s_rst_n,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] pend_mask,
    input logic [7:0]  sts0,
    input logic        s_wr_valid
);
    logic tgt;
    assign tgt = bus_wr && (bus_addr[ADDR_W-1:IDX_W] == '0);

    assert_accept_sets_pend_R2: assert property (@(posedge f_clk) disable iff (!f_rst_n)
        (tgt && !pend_mask[bus_addr[IDX_W-1:0]] && !sts0[STS_FULL])
        |=> pend_mask[$past(bus_addr[IDX_W-1:0])]);

    assert_dup_flags_R6: assert property (@(posedge f_clk) disable iff (!f_rst_n)
        (tgt && pend_mask[bus_addr[IDX_W-1:0]]) |=> sts0[STS_REJ]);

    assert_full_flags_R4: assert property (@(posedge f_clk) disable iff (!f_rst_n)
        (tgt && sts0[STS_FULL]) |=> sts0[STS_REJ]);

    assert_flag_sticky_R6: assert property (@(posedge f_clk) disable iff (!f_rst_n)
        (sts0[STS_REJ] && !(bus_wr && bus_addr == STS_ADDR && bus_wdata[STS_REJ]))
        |=> sts0[STS_REJ]);

    assert_cancel_flush_R9: assert property (@(posedge f_clk) disable iff (!f_rst_n)
        (bus_wr && bus_addr == GW_ADDR && bus_wdata == CANCEL_KEY)
        |=> (pend_mask == '0) && !sts0[STS_FULL] && !sts0[STS_ANY]);

    assert_strobe_single_R1: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        s_wr_valid |=> !s_wr_valid);
endmodule

bind pwb_bridge pwb_bridge_chk #(
    .ADDR_W     (ADDR_W),
    .GW_ADDR    (GW_ADDR),
    .CANCEL_KEY (CANCEL_KEY),
    .STS_ADDR   (STS_ADDR)
) u_chk (
    .f_clk      (f_clk),
    .f_rst_n    (f_rst_n),
    .s_clk      (s_clk),
    .s_rst_n    (s_rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pend_mask  (pend_mask),
    .sts0       (sts0),
    .s_wr_valid (s_wr_valid)
);

// File: tb/pwb_bridge_bench.sv
// Bench for pwb_bridge: sweeps every target index, fills and overflows
// the queue, exercises duplicate refusal, status clearing and cancel.
module pwb_bridge_bench;
    logic        f_clk = 1'b0;
    logic        s_clk = 1'b0;
    logic        f_rst_n = 1'b0;
    logic        s_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] pend_mask;
    logic [7:0]  sts0;
    logic        irq;
    logic        s_wr_valid;
    logic [3:0]  s_wr_idx;
    logic [15:0] s_wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_log = 0;
    int n_app = 0;
    logic [3:0]  log_idx [64];
    logic [15:0] log_dat [64];

    always #5  f_clk = ~f_clk;
    always #35 s_clk = ~s_clk;

    pwb_bridge u_pwb_bridge (
        .f_clk(f_clk), .f_rst_n(f_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pend_mask(pend_mask), .sts0(sts0), .irq(irq),
        .s_clk(s_clk), .s_rst_n(s_rst_n), .s_wr_valid(s_wr_valid),
        .s_wr_idx(s_wr_idx), .s_wr_data(s_wr_data)
    );

    // Log each slow-side strobe mid-cycle.
    always @(negedge s_clk) begin
        if (s_wr_valid && n_log < 64) begin
            log_idx[n_log] = s_wr_idx;
            log_dat[n_log] = s_wr_data;
            n_log++;
        end
    end

    // Count strobes at their rising edge, for the early-clear check.
    always @(posedge s_wr_valid) n_app++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [4:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge f_clk);
        bus_wr = 1'b0;
    endtask

    task automatic drain();
        for (int c = 0; c < 3000; c++) begin
            @(negedge f_clk);
            if (sts0[2:0] == 3'b000) break;
        end
        repeat (20) @(negedge f_clk);
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 16'h1111) ^ 16'h5A00);
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base, start, early;
        repeat (4) @(negedge s_clk);
        f_rst_n = 1'b1; s_rst_n = 1'b1;
        @(negedge f_clk);
        // Reset state
        chk("R8 reset sts0", 32'(sts0), 0);
        chk("R2 reset pend", 32'(pend_mask), 0);
        chk("R6 reset irq", 32'(irq), 0);
        chk("R1 reset strobe", 32'(s_wr_valid), 0);

        // Single write: pending, status, early-clear guard
        base = n_log; start = n_app; early = 0;
        bus(5'd3, 16'h3C3C);
        chk("R2 pend bit3", 32'(pend_mask), 32'h0008);
        chk("R8 any pending", 32'(sts0[0]), 1);
        @(negedge f_clk);
        chk("R8 transfer open", 32'(sts0[1]), 1);
        for (int c = 0; c < 3000; c++) begin
            @(negedge f_clk);
            if (!pend_mask[3]) begin
                if (n_app == start) early = 1;
                break;
            end
        end
        chk("R5 no early clear", 32'(early), 0);
        drain();
        chk("R1 single delivered", 32'({log_idx[base], log_dat[base]}), 32'({4'd3, 16'h3C3C}));
        chk("R8 idle after drain", 32'(sts0), 0);

        // Sweep all 16 indices, four back-to-back per group
        base = n_log;
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < 4; k++) bus(5'(g * 4 + k), pat(g * 4 + k));
            drain();
        end
        chk("R1 sweep count", 32'(n_log - base), 16);
        for (int i = 0; i < 16; i++)
            chk("R1 sweep order", 32'({log_idx[base + i], log_dat[base + i]}), 32'({4'(i), pat(i)}));
        chk("R6 no reject in sweep", 32'(sts0[4]), 0);

        // Overflow: 1 in flight + 4 queued, sixth refused
        base = n_log;
        for (int i = 1; i <= 6; i++) bus(5'(i), 16'(16'h0100 + i));
        chk("R4 full refusal flag", 32'(sts0[4]), 1);
        chk("R4 sixth not pending", 32'(pend_mask), 32'h003E);
        chk("R6 irq on refusal", 32'(irq), 1);
        drain();
        chk("R4 delivered count", 32'(n_log - base), 5);
        for (int i = 0; i < 5; i++)
            chk("R1 burst order", 32'({log_idx[base + i], log_dat[base + i]}),
                32'({4'(i + 1), 16'(16'h0101 + i)}));

        // Status clear and duplicate refusal
        bus(5'h11, 16'h0010);
        chk("R7 w1c clears", 32'(sts0[4]), 0);
        base = n_log;
        bus(5'd7, 16'h7777);
        bus(5'd7, 16'h0BAD);
        chk("R3 duplicate flagged", 32'(sts0[4]), 1);
        chk("R6 irq duplicate", 32'(irq), 1);
        drain();
        chk("R3 only first delivered", 32'(n_log - base), 1);
        chk("R3 first data kept", 32'({log_idx[base], log_dat[base]}), 32'({4'd7, 16'h7777}));
        chk("R6 flag sticky", 32'(sts0[4]), 1);
        bus(5'h11, 16'hFFEF);
        chk("R7 bit4 zero keeps flag", 32'(sts0[4]), 1);
        bus(5'h11, 16'h0010);
        chk("R7 cleared", 32'(sts0[4]), 0);
        chk("R6 irq follows", 32'(irq), 0);

        // Cancel with one write in flight and two queued, then re-post
        base = n_log;
        bus(5'd8, 16'h0808);
        bus(5'd9, 16'h0909);
        bus(5'd10, 16'h0A0A);
        bus(5'h10, 16'hA2C5);
        chk("R9 pend cleared", 32'(pend_mask), 0);
        chk("R9 queue emptied", 32'(sts0[2:0]), 32'b010);
        bus(5'd8, 16'h8888);
        chk("R11 accepted after cancel", 32'(pend_mask), 32'h0100);
        drain();
        chk("R9 cancelled not delivered", 32'(n_log - base), 1);
        chk("R11 new write delivered", 32'({log_idx[base], log_dat[base]}), 32'({4'd8, 16'h8888}));
        chk("R6 no flag from cancel", 32'(sts0[4]), 0);

        // Wrong keys at the gateway
        base = n_log;
        bus(5'd12, 16'h0C0C);
        bus(5'h10, 16'h1234);
        bus(5'h10, 16'hA2C4);
        chk("R10 pending kept", 32'(pend_mask), 32'h1000);
        drain();
        chk("R10 still delivered", 32'({log_idx[base], log_dat[base]}), 32'({4'd12, 16'h0C0C}));
        chk("R10 count", 32'(n_log - base), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule